// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Read Slave

This block models the slave side of a 256-byte two-wire serial EEPROM. It does not sit on a real open-drain bus. Software drives it by writing clock and data line levels one update at a time. Each update is a single-cycle strobe that carries the new SCL and SDA levels. The block compares each update with the line levels it holds from the previous update. From that comparison it classifies the update as a start, a stop, a clean SCL rising edge, a faulty rising edge, or a quiet change.

A transaction opens with a start condition and then carries two bytes.

- **Control byte.** The slave receives it MSB-first and acknowledges it. Bit 0 of this byte selects read mode (1) or write mode (0).
- **Address byte.** The slave receives it the same way. After it, the slave fetches the byte stored at that address and acknowledges again. It then waits for the next start.

In read mode, the slave shifts out its data register MSB-first while the address byte is being clocked in. That register holds the byte fetched at the end of the previous transaction. The stored contents are read-only. They come from an image computed from parameters. Software reads back the SDA level that the slave currently presents, and it reads it one cycle after each update.

Top module: `i2cee_slave`

## Requirements
- R1: After reset, `sda_rd` is 1, the bit count is 0 and no acknowledge is pending, so no acknowledge appears before a start.
- R2: A cycle with `upd` low changes nothing. In a cycle with `upd` high, `sda_rd` takes the written `sda_set` level from the next clock edge, unless R5, R6, R8 or R12 say otherwise.
- R3: A start condition is an update with SCL high before and after while SDA falls. It sets the bit count to 1 and clears the command byte, including in the middle of a byte.
- R4: While the bit count is 0 and no acknowledge is pending, every update other than a start leaves the sequence state unchanged.
- R5: A bit is taken only on an update where SCL rises and SDA keeps its held level. A rising edge with a changed SDA level takes no bit and does not advance the count.
- R6: After the eighth control bit, the next SCL rising edge makes `sda_rd` 0 whatever the master writes, and the pending acknowledge clears.
- R7: The next eight bits form the address MSB-first. After the eighth, the byte at that address is loaded into the data register, an acknowledge follows on the next rising edge, and the bit count returns to 0.
- R8: In read mode (control bit 0 = 1), on each of the eight address-phase rising edges, `sda_rd` shows the data register MSB. The data register then shifts left by one.
- R9: After the address acknowledge, the slave ignores rising edges until a new start.
- R10: The image byte at address a is `((a*IMG_MUL + IMG_ADD) mod 256) XOR IMG_XOR`.
- R11: In write mode (control bit 0 = 0), the slave never drives during the address phase, so `sda_rd` follows `sda_set`.
- R12: A stop condition is SDA rising while SCL stays high. It takes no bit and leaves the bit count and command unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | One-cycle strobe: apply a new line-level pair |
| scl_set | input | 1 | Clock line level carried by the update |
| sda_set | input | 1 | Data line level written by the master |
| sda_rd | output | 1 | Data line level currently presented by the slave |

## Verification
Every result this block produces is the `sda_rd` level that follows one update. That level is registered on the same clock edge that samples `upd` high, so it is due exactly one edge after the strobe. The driver queues the expected level for each update as it issues the strobe. The monitor pops the queue at the falling edge that follows the sampling edge, and no later. Acknowledges, data bits and ignored edges are therefore all compared at that same single-edge distance. A bit that is counted early or late therefore appears as a mismatch on a specific update.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  // Classification of one line update against the held levels.
  typedef enum logic [2:0] {
    LN_QUIET    = 3'd0,
    LN_START    = 3'd1,
    LN_STOP     = 3'd2,
    LN_RISE_OK  = 3'd3,
    LN_RISE_BAD = 3'd4
  } line_ev_e;

endpackage

// File: rtl/i2cee_linecls.sv
module i2cee_linecls
  import i2cee_pkg::*;
(
  input  logic     prev_scl,
  input  logic     prev_sda,
  input  logic     nxt_scl,
  input  logic     nxt_sda,
  output line_ev_e ev
);

  always_comb begin
    if (prev_scl && nxt_scl && (prev_sda != nxt_sda)) begin
      // Data moves while the clock is high: a bus condition.
      ev = nxt_sda ? LN_STOP : LN_START;
    end else if (!prev_scl && nxt_scl) begin
      // Clock rising: a bit is valid only if data held still.
      ev = (prev_sda == nxt_sda) ? LN_RISE_OK : LN_RISE_BAD;
    end else begin
      ev = LN_QUIET;
    end
  end

endmodule

// File: rtl/i2cee_image.sv
module i2cee_image #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned IMG_MUL = 37,
  parameter int unsigned IMG_ADD = 11,
  parameter int unsigned IMG_XOR = 92
) (
  input  logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] rdata
);

  localparam logic [BYTE_W-1:0] XOR_V = BYTE_W'(IMG_XOR);

  // Contents are computed from the address, so no stored table is needed.
  always_comb begin
    rdata = BYTE_W'(32'(addr) * 32'(IMG_MUL) + 32'(IMG_ADD)) ^ XOR_V;
  end

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned IMG_MUL = 37,
  parameter int unsigned IMG_ADD = 11,
  parameter int unsigned IMG_XOR = 92
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic scl_set,
  input  logic sda_set,
  output logic sda_rd
);

  localparam int unsigned CMD_END = BYTE_W + 1;
  localparam int unsigned ADR_END = 2 * BYTE_W + 1;
  localparam int unsigned TICK_W  = $clog2(ADR_END + 1);
  localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] T_ADR  = TICK_W'(ADR_END);
  localparam logic [TICK_W-1:0] T_LAST = TICK_W'(ADR_END - 1);

  // Held state
  logic              scl_q, sda_q;
  logic [TICK_W-1:0] tick_q;
  logic [BYTE_W-1:0] cmd_q, addr_q, data_q;
  logic              ack_q;

  // Next state
  logic              scl_n, sda_n;
  logic [TICK_W-1:0] tick_n;
  logic [BYTE_W-1:0] cmd_n, addr_n, data_n;
  logic              ack_n;

  line_ev_e          ev;
  logic [TICK_W-1:0] tick_inc;
  logic [BYTE_W-1:0] fetch_addr, fetch_data;
  logic              idle;
  logic              rise_any;

  i2cee_linecls u_cls (
    .prev_scl (scl_q),
    .prev_sda (sda_q),
    .nxt_scl  (scl_set),
    .nxt_sda  (sda_set),
    .ev       (ev)
  );

  assign fetch_addr = {addr_q[BYTE_W-2:0], sda_set};

  i2cee_image #(
    .BYTE_W  (BYTE_W),
    .IMG_MUL (IMG_MUL),
    .IMG_ADD (IMG_ADD),
    .IMG_XOR (IMG_XOR)
  ) u_img (
    .addr  (fetch_addr),
    .rdata (fetch_data)
  );

  assign tick_inc = tick_q + 1'b1;
  assign idle     = (tick_q == '0) && !ack_q;
  assign rise_any = (ev == LN_RISE_OK) || (ev == LN_RISE_BAD);

  // Next-state logic, evaluated for the update in this cycle.
  always_comb begin
    scl_n  = scl_set;
    sda_n  = sda_set;
    tick_n = tick_q;
    cmd_n  = cmd_q;
    addr_n = addr_q;
    data_n = data_q;
    ack_n  = ack_q;
    if (ev == LN_START) begin
      tick_n = T_ONE;
      cmd_n  = '0;
    end else if (ev == LN_STOP) begin
      // A stop only updates the held levels.
      tick_n = tick_q;
    end else if (idle) begin
      // Waiting for a start.
      tick_n = tick_q;
    end else if (rise_any) begin
      if (ack_q) begin
        sda_n = 1'b0;
        ack_n = 1'b0;
      end else if (ev == LN_RISE_OK) begin
        if (tick_q < T_CMD) begin
          cmd_n  = {cmd_q[BYTE_W-2:0], sda_set};
          tick_n = tick_inc;
          if (tick_inc == T_CMD) begin
            ack_n = 1'b1;
          end
        end else if (tick_q < T_ADR) begin
          if (cmd_q[0]) begin
            sda_n = data_q[BYTE_W-1];
          end
          addr_n = fetch_addr;
          data_n = {data_q[BYTE_W-2:0], 1'b0};
          tick_n = tick_inc;
          if (tick_inc == T_ADR) begin
            data_n = fetch_data;
            ack_n  = 1'b1;
            tick_n = '0;
          end
        end else begin
          sda_n = 1'b0;
        end
      end
    end
  end

  // State registers, loaded only on an update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
    end else if (upd) begin
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      tick_q <= tick_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      data_q <= data_n;
      ack_q  <= ack_n;
    end
  end

  assign sda_rd = sda_q;

  // R2
  hold_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(sda_rd) && $stable(tick_q)));

  // R3
  start_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ev == LN_START) |=> (tick_q == T_ONE && cmd_q == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && idle && ev != LN_START) |=> (tick_q == '0 && !ack_q && $stable(addr_q)));

  // R5
  bad_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ack_q && ev == LN_RISE_BAD) |=> $stable(tick_q));

  // R6
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ack_q && rise_any) |=> (!sda_rd && !ack_q));

  // R7
  fetch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ack_q && ev == LN_RISE_OK && tick_q == T_LAST) |=> (tick_q == '0 && ack_q));

  // R7
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= T_LAST);

  // R8
  read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ack_q && ev == LN_RISE_OK && cmd_q[0] && tick_q >= T_CMD && tick_q < T_ADR)
    |=> (sda_rd == $past(data_q[BYTE_W-1])));

  // R11
  write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ack_q && ev == LN_RISE_OK && !cmd_q[0] && tick_q >= T_CMD && tick_q < T_ADR)
    |=> (sda_rd == $past(sda_set)));

endmodule

// File: tb/sim_i2cee_slave.sv
module sim_i2cee_slave;

  localparam int unsigned BW  = 8;
  localparam int unsigned MUL = 37;
  localparam int unsigned ADD = 11;
  localparam int unsigned XRV = 92;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic scl_set = 1'b1;
  logic sda_set = 1'b1;
  logic sda_rd;
  logic upd_d = 1'b0;

  int total = 0;
  int bad = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  i2cee_slave #(.BYTE_W(BW), .IMG_MUL(MUL), .IMG_ADD(ADD), .IMG_XOR(XRV)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .scl_set (scl_set),
    .sda_set (sda_set),
    .sda_rd  (sda_rd)
  );

  // R10: expected image byte
  function automatic logic [7:0] img(input logic [7:0] a);
    logic [31:0] v;
    v = 32'(a) * 32'(MUL) + 32'(ADD);
    return v[7:0] ^ 8'(XRV);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sda_rd=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Monitor: compares one edge after each sampled update.
  always @(posedge clk) upd_d <= upd;
  always @(negedge clk) begin
    if (upd_d && exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(sda_rd, e, t);
    end
  end

  // Driver
  task automatic do_upd(input logic s, input logic d, input logic e, input string tag);
    @(negedge clk);
    upd = 1'b1;
    scl_set = s;
    sda_set = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic bitx(input logic b, input logic e, input string tag);
    do_upd(1'b0, b, b, tag);
    do_upd(1'b1, b, e, tag);
  endtask

  task automatic byte_out(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) bitx(v[i], v[i], tag);
  endtask

  task automatic byte_rd(input logic [7:0] m, input logic [7:0] d, input string tag);
    for (int i = 7; i >= 0; i--) bitx(m[i], d[i], tag);
  endtask

  task automatic ack(input string tag);
    bitx(1'b1, 1'b0, tag);
  endtask

  task automatic go_start(input string tag);
    do_upd(1'b0, 1'b1, 1'b1, tag);
    do_upd(1'b1, 1'b1, 1'b1, tag);
    do_upd(1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sda_rd, 1'b1, "R1 reset level");

    // R2: pins move with upd low
    scl_set = 1'b0;
    sda_set = 1'b0;
    repeat (3) @(negedge clk);
    check(sda_rd, 1'b1, "R2 no strobe no change");
    do_upd(1'b0, 1'b0, 1'b0, "R2 follow low");
    do_upd(1'b0, 1'b1, 1'b1, "R2 follow high");

    // R1 / R4: no start yet, so no acknowledge ever
    for (int i = 0; i < 10; i++) bitx(1'b1, 1'b1, "R4 idle before start");

    // Write-mode transaction to address 0x5A
    go_start("R3 start");
    byte_out(8'hA0, "R6 control byte");
    ack("R6 control ack");
    byte_out(8'h5A, "R11 write address");
    ack("R7 address ack");
    for (int i = 0; i < 9; i++) bitx(1'b1, 1'b1, "R9 idle after ack");

    // Read transaction: shifts out image[0x5A], fetches 0xFF
    go_start("R3 start");
    byte_out(8'hA1, "R8 control byte");
    ack("R6 control ack");
    byte_rd(8'hFF, img(8'h5A), "R8 R10 data 0x5A");
    ack("R7 address ack");

    go_start("R3 start");
    byte_out(8'hA1, "R8 control byte");
    ack("R6 control ack");
    byte_rd(8'h00, img(8'hFF), "R7 R10 data 0xFF");
    ack("R7 address ack");

    // R5: faulty rising edge right after start
    go_start("R5 start");
    do_upd(1'b0, 1'b0, 1'b0, "R5 low phase");
    do_upd(1'b1, 1'b1, 1'b1, "R5 faulty rise");
    byte_out(8'hA1, "R5 full byte after fault");
    ack("R5 ack after eight good bits");
    byte_rd(8'h3C, img(8'h00), "R8 R10 data 0x00");
    ack("R7 address ack");

    // R3: start in the middle of the control byte
    go_start("R3 start");
    bitx(1'b1, 1'b1, "R3 partial");
    bitx(1'b0, 1'b0, "R3 partial");
    bitx(1'b1, 1'b1, "R3 partial");
    do_upd(1'b1, 1'b0, 1'b0, "R3 restart");
    byte_out(8'hA1, "R3 byte after restart");
    ack("R3 ack after restart");
    byte_rd(8'hFF, img(8'h3C), "R8 R10 data 0x3C");
    ack("R7 address ack");

    // R12: stop inside the control byte is not a bit and not a reset
    go_start("R12 start");
    bitx(1'b1, 1'b1, "R12 bits");
    bitx(1'b0, 1'b0, "R12 bits");
    bitx(1'b1, 1'b1, "R12 bits");
    bitx(1'b0, 1'b0, "R12 bits");
    do_upd(1'b1, 1'b1, 1'b1, "R12 stop");
    bitx(1'b0, 1'b0, "R12 bits");
    bitx(1'b0, 1'b0, "R12 bits");
    bitx(1'b0, 1'b0, "R12 bits");
    bitx(1'b1, 1'b1, "R12 bits");
    ack("R12 ack after stop");
    byte_rd(8'h00, img(8'hFF), "R8 R10 data 0xFF again");
    ack("R7 address ack");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R2 scoreboard: pending=%0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule